// File: doc/BRIEF.md
# Load/Store Address Alignment and Data Extension Unit

This unit sits between the integer address adder and the data memory port for ordinary loads and stores. For each request it forms the effective address from a base register and a 12-bit signed offset. It decides whether the access is legal and aligned for its size, and then either issues a memory request or raises an exception carrying the computed address. A platform input chooses whether misaligned accesses are allowed through or trapped.

On stores it places the low bytes of the source register into every byte lane of the data bus and produces a byte-enable mask from the address low bits and the access size. Loads produce the same mask. The unit remembers the lane offset, size and signedness of the one outstanding load. When memory returns the full bus word, it picks out the addressed bytes and extends them to the register width, with zeros or with the sign bit, to form the destination-register write. Address translation and caching are handled elsewhere.

Top module: `lsu_align_ext`

## Requirements
- R1: The effective address equals `req_base` plus `req_imm` sign-extended to XLEN bits. It appears on `mem_addr`, or on `exc_addr` for a faulting request.
- R2: Size codes on `req_width` are 00 byte, 01 half, 10 word and 11 double. A byte is always aligned. A half needs address bit 0 clear, a word needs bits 1:0 clear and a double needs bits 2:0 clear. With `mis_ok` low, a misaligned request issues no memory request and raises `exc_valid` with `exc_code` 01 for a load or 10 for a store.
- R3: With `mis_ok` high, a legal misaligned request issues a memory request and raises no exception.
- R4: These requests are illegal and raise `exc_code` 11 with no memory request: an unsigned load whose size equals the register width, and any double access when XLEN is 32. Illegality takes priority over misalignment. `req_unsigned` is ignored for stores.
- R5: A store drives `mem_we` high. In every byte lane, `mem_wdata` carries the byte of the low 8×size bits of `req_src` at index (lane mod size). `mem_be` has ones at lanes offset through offset+size−1, where the offset is the effective address modulo XLEN/8. Lanes past the bus edge are not enabled.
- R6: A load drives `mem_we` low with the same enable rule. The returned word is shifted right by the saved lane offset and its low 8×size bits are written to `rd_data`. The upper bits are zero-filled when the load's unsigned bit was set, and copy the top loaded bit otherwise.
- R7: A response arriving while no load is outstanding, such as after a faulting load, causes no destination write.
- R8: During reset, `mem_req_valid`, `exc_valid` and `rd_we` are low.
- R9: Request results appear exactly one cycle after `req_valid`, and `rd_we` exactly one cycle after `rsp_valid`. No result appears without such a cause.
- R10: If a response and a new load arrive in the same cycle, the response is extended using the earlier load's offset, size and signedness. The new load becomes the outstanding one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mis_ok | input | 1 | Platform flag: misaligned accesses allowed |
| req_valid | input | 1 | Request strobe |
| req_store | input | 1 | 1 store, 0 load |
| req_unsigned | input | 1 | Load zero-extends when set |
| req_width | input | 2 | Access size code |
| req_base | input | XLEN | Base register value |
| req_imm | input | IMM_W | Signed address offset |
| req_src | input | XLEN | Store source register |
| rsp_valid | input | 1 | Load data returned |
| rsp_data | input | XLEN | Returned bus word |
| mem_req_valid | output | 1 | Memory request issued |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | XLEN | Effective address |
| mem_be | output | XLEN/8 | Byte enables |
| mem_wdata | output | XLEN | Lane-replicated store data |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 2 | 01 load misaligned, 10 store misaligned, 11 illegal |
| exc_addr | output | XLEN | Faulting effective address |
| rd_we | output | 1 | Destination write |
| rd_data | output | XLEN | Extended load value |

## Verification
The request path and the load-return path can act in one cycle. The return must be extended with the earlier load's context, while the saved context is overwritten by a new load of a different size and signedness. The bench drives a response for a signed word load in the same cycle as it issues an unsigned half load. It then expects the word result sign-extended, and the later response for the half to come back zero-extended from its own lane offset. A faulting load followed by a stray response checks that the cleared outstanding state blocks the write.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'b00,
      SZ_H = 2'b01,
      SZ_W = 2'b10,
      SZ_D = 2'b11
   } size_e;

   typedef enum logic [1:0] {
      EX_NONE    = 2'b00,
      EX_LD_MIS  = 2'b01,
      EX_ST_MIS  = 2'b10,
      EX_ILLEGAL = 2'b11
   } exc_e;

   function automatic int unsigned size_bytes(size_e s);
      return 32'd1 << s;
   endfunction

endpackage

// File: rtl/lsu_addr_check.sv
module lsu_addr_check
   import lsu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 12
) (
   input  logic [XLEN-1:0]  base,
   input  logic [IMM_W-1:0] imm,
   input  size_e            size,
   input  logic             is_store,
   input  logic             is_unsigned,
   input  logic             mis_ok,
   output logic [XLEN-1:0]  ea,
   output logic             issue,
   output exc_e             fault
);
   localparam int NB = XLEN / 8;

   logic aligned;
   logic too_wide;
   logic uns_full;

   assign ea = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

   always_comb begin
      case (size)
         SZ_B:    aligned = 1'b1;
         SZ_H:    aligned = ~ea[0];
         SZ_W:    aligned = (ea[1:0] == 2'b00);
         default: aligned = (ea[2:0] == 3'b000);
      endcase
   end

   generate
      if (XLEN == 32) begin : g_narrow
         assign too_wide = (size == SZ_D);
      end else begin : g_wide
         assign too_wide = 1'b0;
      end
   endgenerate

   assign uns_full = !is_store && is_unsigned && (size_bytes(size) == NB);

   always_comb begin
      if (too_wide || uns_full)
         fault = EX_ILLEGAL;
      else if (!aligned && !mis_ok)
         fault = is_store ? EX_ST_MIS : EX_LD_MIS;
      else
         fault = EX_NONE;
   end

   assign issue = (fault == EX_NONE);

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int NB    = XLEN / 8,
   parameter int OFF_W = $clog2(XLEN / 8)
) (
   input  size_e            size,
   input  logic [OFF_W-1:0] off,
   input  logic [XLEN-1:0]  src,
   output logic [XLEN-1:0]  wdata,
   output logic [NB-1:0]    be
);
   generate
      for (genvar i = 0; i < NB; i++) begin : g_lane
         localparam int unsigned LANE = i;
         logic [7:0] lane_b;
         logic       lane_e;
         always_comb begin
            int unsigned span;
            int unsigned pick;
            int unsigned o;
            span   = size_bytes(size);
            pick   = LANE & (span - 1);
            o      = 32'(off);
            lane_b = src[8*pick +: 8];
            lane_e = (LANE >= o) && (LANE < o + span);
         end
         assign wdata[8*i +: 8] = lane_b;
         assign be[i]           = lane_e;
      end
   endgenerate

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
   import lsu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int OFF_W = $clog2(XLEN / 8)
) (
   input  logic [XLEN-1:0]  raw,
   input  logic [OFF_W-1:0] off,
   input  size_e            size,
   input  logic             is_unsigned,
   output logic [XLEN-1:0]  value
);
   logic [XLEN-1:0] shifted;
   logic            sign;
   logic            fill;

   always_comb begin
      int unsigned nbits;
      shifted = raw >> {off, 3'b000};
      case (size)
         SZ_B:    sign = shifted[7];
         SZ_H:    sign = shifted[15];
         SZ_W:    sign = shifted[31];
         default: sign = shifted[XLEN-1];
      endcase
      fill  = is_unsigned ? 1'b0 : sign;
      nbits = 8 * size_bytes(size);
      for (int j = 0; j < XLEN; j++)
         value[j] = (j < int'(nbits)) ? shifted[j] : fill;
   end

endmodule

// File: rtl/lsu_align_ext.sv
module lsu_align_ext
   import lsu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int IMM_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mis_ok,
   input  logic                 req_valid,
   input  logic                 req_store,
   input  logic                 req_unsigned,
   input  logic [1:0]           req_width,
   input  logic [XLEN-1:0]      req_base,
   input  logic [IMM_W-1:0]     req_imm,
   input  logic [XLEN-1:0]      req_src,
   input  logic                 rsp_valid,
   input  logic [XLEN-1:0]      rsp_data,
   output logic                 mem_req_valid,
   output logic                 mem_we,
   output logic [XLEN-1:0]      mem_addr,
   output logic [XLEN/8-1:0]    mem_be,
   output logic [XLEN-1:0]      mem_wdata,
   output logic                 exc_valid,
   output logic [1:0]           exc_code,
   output logic [XLEN-1:0]      exc_addr,
   output logic                 rd_we,
   output logic [XLEN-1:0]      rd_data
);
   localparam int NB    = XLEN / 8;
   localparam int OFF_W = $clog2(NB);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("lsu_align_ext: XLEN must be 32 or 64");
      end
      if (IMM_W < 1 || IMM_W >= XLEN) begin : g_bad_imm
         $error("lsu_align_ext: IMM_W out of range");
      end
   endgenerate

   size_e           req_sz;
   logic [XLEN-1:0] ea;
   logic            issue;
   exc_e            fault;
   logic [XLEN-1:0] st_data;
   logic [NB-1:0]   st_be;
   logic [XLEN-1:0] ld_val;

   logic             pend;
   logic [OFF_W-1:0] ctx_off;
   size_e            ctx_sz;
   logic             ctx_uns;
   exc_e             exc_q;

   assign req_sz   = size_e'(req_width);
   assign exc_code = exc_q;

   lsu_addr_check #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
      .base(req_base), .imm(req_imm), .size(req_sz), .is_store(req_store),
      .is_unsigned(req_unsigned), .mis_ok(mis_ok),
      .ea(ea), .issue(issue), .fault(fault)
   );

   lsu_store_lanes #(.XLEN(XLEN), .NB(NB), .OFF_W(OFF_W)) u_st (
      .size(req_sz), .off(ea[OFF_W-1:0]), .src(req_src),
      .wdata(st_data), .be(st_be)
   );

   lsu_load_ext #(.XLEN(XLEN), .OFF_W(OFF_W)) u_ld (
      .raw(rsp_data), .off(ctx_off), .size(ctx_sz), .is_unsigned(ctx_uns),
      .value(ld_val)
   );

   logic new_load;
   assign new_load = req_valid && issue && !req_store;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_req_valid <= 1'b0;
         mem_we        <= 1'b0;
         mem_addr      <= '0;
         mem_be        <= '0;
         mem_wdata     <= '0;
         exc_valid     <= 1'b0;
         exc_q         <= EX_NONE;
         exc_addr      <= '0;
         rd_we         <= 1'b0;
         rd_data       <= '0;
         pend          <= 1'b0;
         ctx_off       <= '0;
         ctx_sz        <= SZ_B;
         ctx_uns       <= 1'b0;
      end else begin
         mem_req_valid <= req_valid && issue;
         exc_valid     <= req_valid && !issue;
         if (req_valid) begin
            mem_we    <= req_store;
            mem_addr  <= ea;
            mem_be    <= st_be;
            mem_wdata <= st_data;
            exc_q     <= fault;
            exc_addr  <= ea;
         end
         rd_we <= rsp_valid && pend;
         if (rsp_valid && pend)
            rd_data <= ld_val;
         if (new_load) begin
            pend    <= 1'b1;
            ctx_off <= ea[OFF_W-1:0];
            ctx_sz  <= req_sz;
            ctx_uns <= req_unsigned;
         end else if (rsp_valid) begin
            pend <= 1'b0;
         end
      end
   end

   // R2
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> !mem_req_valid);

   // R3
   permit_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mis_ok && fault != EX_ILLEGAL) |=> mem_req_valid);

   // R5
   be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_be != '0));

   // R9
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> $past(rsp_valid));

   // R7
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> $past(pend));

endmodule

// File: tb/tb_lsu_align_ext.sv
`timescale 1ns/1ps
module tb_lsu_align_ext;

   typedef struct {
      bit          issue;
      bit          we;
      logic [63:0] addr;
      logic [7:0]  be;
      logic [63:0] wdata;
      bit          exc;
      logic [1:0]  code;
      string       tag;
   } req_exp_t;

   typedef struct {
      bit          we;
      logic [63:0] data;
      string       tag;
   } rd_exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        mis_ok = 1'b0, req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
   logic [1:0]  req_width = 2'b00;
   logic [63:0] req_base = '0, req_src = '0, rsp_data = '0;
   logic [11:0] req_imm = '0;
   logic        rsp_valid = 1'b0;
   logic        mem_req_valid, mem_we, exc_valid, rd_we;
   logic [63:0] mem_addr, mem_wdata, exc_addr, rd_data;
   logic [7:0]  mem_be;
   logic [1:0]  exc_code;

   lsu_align_ext #(.XLEN(64), .IMM_W(12)) dut (
      .clk(clk), .rst_n(rst_n), .mis_ok(mis_ok), .req_valid(req_valid),
      .req_store(req_store), .req_unsigned(req_unsigned), .req_width(req_width),
      .req_base(req_base), .req_imm(req_imm), .req_src(req_src),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .exc_valid(exc_valid),
      .exc_code(exc_code), .exc_addr(exc_addr), .rd_we(rd_we), .rd_data(rd_data)
   );

   // narrow instance for the 32-bit illegal cases
   logic        n_valid = 1'b0, n_unsigned = 1'b0;
   logic [1:0]  n_width = 2'b00;
   logic        n_req_valid, n_we, n_exc_valid, n_rd_we;
   logic [31:0] n_addr, n_wdata, n_exc_addr, n_rd_data;
   logic [3:0]  n_be;
   logic [1:0]  n_exc_code;

   lsu_align_ext #(.XLEN(32), .IMM_W(12)) dut32 (
      .clk(clk), .rst_n(rst_n), .mis_ok(1'b0), .req_valid(n_valid),
      .req_store(1'b0), .req_unsigned(n_unsigned), .req_width(n_width),
      .req_base(32'h0000_2000), .req_imm(12'h000), .req_src(32'h0),
      .rsp_valid(1'b0), .rsp_data(32'h0),
      .mem_req_valid(n_req_valid), .mem_we(n_we), .mem_addr(n_addr),
      .mem_be(n_be), .mem_wdata(n_wdata), .exc_valid(n_exc_valid),
      .exc_code(n_exc_code), .exc_addr(n_exc_addr), .rd_we(n_rd_we), .rd_data(n_rd_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   req_exp_t req_q[$];
   rd_exp_t  rd_q[$];

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] model_ext(logic [63:0] data, int off, int w, bit uns);
      int span = 1 << w;
      logic [63:0] v = data >> (off * 8);
      logic [63:0] mask;
      if (span == 8) return v;
      mask = (64'd1 << (8 * span)) - 64'd1;
      v = v & mask;
      if (!uns && v[8*span-1]) v = v | ~mask;
      return v;
   endfunction

   task automatic step();
      @(negedge clk);
      req_valid = 1'b0;
      rsp_valid = 1'b0;
   endtask

   task automatic issue(bit st, bit uns, int w, logic [63:0] base, logic [11:0] imm,
                        logic [63:0] src, bit mok, string tag);
      req_exp_t e;
      int span = 1 << w;
      int off;
      bit aligned, illegal;
      req_valid = 1'b1; req_store = st; req_unsigned = uns; req_width = w[1:0];
      req_base = base; req_imm = imm; req_src = src; mis_ok = mok;
      e.addr  = base + {{52{imm[11]}}, imm};
      off     = int'(e.addr[2:0]);
      aligned = (e.addr & 64'(span - 1)) == 64'd0;
      illegal = !st && uns && span == 8;
      e.tag   = tag;
      e.we    = st;
      if (illegal) begin e.exc = 1; e.code = 2'b11; end
      else if (!aligned && !mok) begin e.exc = 1; e.code = st ? 2'b10 : 2'b01; end
      else begin e.exc = 0; e.code = 2'b00; end
      e.issue = !e.exc;
      for (int l = 0; l < 8; l++) begin
         e.be[l] = (l >= off) && (l < off + span);
         e.wdata[8*l +: 8] = src[8*(l % span) +: 8];
      end
      req_q.push_back(e);
   endtask

   task automatic respond(logic [63:0] data, bit exp_we, logic [63:0] exp_val, string tag);
      rd_exp_t r;
      rsp_valid = 1'b1; rsp_data = data;
      r.we = exp_we; r.data = exp_val; r.tag = tag;
      rd_q.push_back(r);
   endtask

   // monitor
   initial begin
      forever begin
         bit h_req, h_rsp;
         @(posedge clk);
         h_req = req_valid && rst_n;
         h_rsp = rsp_valid && rst_n;
         #1;
         if (rst_n) begin
            if (h_req) begin
               req_exp_t e;
               if (req_q.size() == 0) chk(0, "R9", "request queue empty", 0, 0);
               else begin
                  e = req_q.pop_front();
                  chk(mem_req_valid == e.issue, e.tag, "mem_req_valid", 64'(mem_req_valid), 64'(e.issue));
                  chk(exc_valid == e.exc, e.tag, "exc_valid", 64'(exc_valid), 64'(e.exc));
                  if (e.issue) begin
                     chk(mem_addr == e.addr, e.tag, "mem_addr", mem_addr, e.addr);
                     chk(mem_be == e.be, e.tag, "mem_be", 64'(mem_be), 64'(e.be));
                     chk(mem_we == e.we, e.tag, "mem_we", 64'(mem_we), 64'(e.we));
                     if (e.we) chk(mem_wdata == e.wdata, e.tag, "mem_wdata", mem_wdata, e.wdata);
                  end
                  if (e.exc) begin
                     chk(exc_code == e.code, e.tag, "exc_code", 64'(exc_code), 64'(e.code));
                     chk(exc_addr == e.addr, e.tag, "exc_addr", exc_addr, e.addr);
                  end
               end
            end else begin
               chk(!mem_req_valid && !exc_valid, "R9", "idle request outputs",
                   64'({mem_req_valid, exc_valid}), 64'd0);
            end
            if (h_rsp) begin
               rd_exp_t r;
               if (rd_q.size() == 0) chk(0, "R9", "response queue empty", 0, 0);
               else begin
                  r = rd_q.pop_front();
                  chk(rd_we == r.we, r.tag, "rd_we", 64'(rd_we), 64'(r.we));
                  if (r.we) chk(rd_data == r.data, r.tag, "rd_data", rd_data, r.data);
               end
            end else begin
               chk(!rd_we, "R9", "idle rd_we", 64'(rd_we), 64'd0);
            end
         end
      end
   end

   // watchdog
   initial begin
      #200000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      #12;
      // R8 reset state
      chk(!mem_req_valid && !exc_valid && !rd_we, "R8", "reset outputs",
          64'({mem_req_valid, exc_valid, rd_we}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R6 signed word load at lane 4
      step(); issue(0, 0, 2, 64'h1000, 12'h004, 0, 0, "R1_R6");
      step(); d = 64'h8000_0001_1234_5678;
      respond(d, 1, 64'hFFFF_FFFF_8000_0001, "R6_signed");
      // R6 unsigned word load
      step(); issue(0, 1, 2, 64'h1000, 12'h004, 0, 0, "R6");
      step(); respond(d, 1, 64'h0000_0000_8000_0001, "R6_unsigned");
      // R1 negative offset byte load
      step(); issue(0, 0, 0, 64'h1000, 12'hFFF, 0, 0, "R1_negimm");
      step(); respond(64'h9A00_0000_0000_0000, 1, 64'hFFFF_FFFF_FFFF_FF9A, "R6_byte");
      // R2 misaligned half load, then R7 stray response
      step(); issue(0, 0, 1, 64'h1000, 12'h001, 0, 0, "R2_ld");
      step(); respond(64'hFFFF, 0, 0, "R7");
      // R2 misaligned word store
      step(); issue(1, 0, 2, 64'h1000, 12'h002, 64'h1122_3344_5566_7788, 0, "R2_st");
      // R2 misaligned double load
      step(); issue(0, 0, 3, 64'h1000, 12'h004, 0, 0, "R2_dbl");
      // R3 permitted misaligned half load
      step(); issue(0, 1, 1, 64'h1000, 12'h001, 0, 1, "R3");
      step(); respond(64'h0000_0000_00BE_EF00, 1, 64'h0000_0000_0000_BEEF, "R3_R6");
      mis_ok = 1'b0;
      // R5 stores of each size
      step(); issue(1, 0, 0, 64'h1000, 12'h003, 64'h5555_0000_0000_12AB, 0, "R5_byte");
      step(); issue(1, 1, 1, 64'h1000, 12'h006, 64'h0000_0000_0000_BEEF, 0, "R5_half_R4");
      step(); issue(1, 0, 2, 64'h1000, 12'h004, 64'hAAAA_BBBB_CAFE_F00D, 0, "R5_word");
      step(); issue(1, 0, 3, 64'h1000, 12'h008, 64'h0123_4567_89AB_CDEF, 0, "R5_dbl");
      // R4 unsigned full-width load, and priority over misalignment
      step(); issue(0, 1, 3, 64'h1000, 12'h000, 0, 0, "R4");
      step(); issue(0, 1, 3, 64'h1000, 12'h001, 0, 0, "R4_priority");
      // R10 response together with a new load
      step(); issue(0, 0, 2, 64'h2000, 12'h000, 0, 0, "R10_a");
      step(); issue(0, 1, 1, 64'h2000, 12'h006, 0, 0, "R10_b");
      respond(64'h0000_0000_F000_0002, 1, 64'hFFFF_FFFF_F000_0002, "R10");
      step(); respond(64'h8001_0000_0000_0000, 1, 64'h0000_0000_0000_8001, "R10_next");
      step();
      step();

      // R4 narrow register width
      @(negedge clk); n_valid = 1'b1; n_width = 2'b11; n_unsigned = 1'b0;
      @(posedge clk); #1;
      chk(n_exc_valid && n_exc_code == 2'b11 && !n_req_valid, "R4", "xlen32 double",
          64'({n_exc_valid, n_exc_code, n_req_valid}), 64'b1110);
      @(negedge clk); n_width = 2'b10; n_unsigned = 1'b1;
      @(posedge clk); #1;
      chk(n_exc_valid && n_exc_code == 2'b11 && !n_req_valid, "R4", "xlen32 unsigned word",
          64'({n_exc_valid, n_exc_code, n_req_valid}), 64'b1110);
      @(negedge clk); n_width = 2'b01; n_unsigned = 1'b1;
      @(posedge clk); #1;
      chk(!n_exc_valid && n_req_valid && n_be == 4'b0011, "R4", "xlen32 unsigned half",
          64'({n_exc_valid, n_req_valid, n_be}), 64'b010011);
      @(negedge clk); n_valid = 1'b0;
      step(); step();

      chk(req_q.size() == 0 && rd_q.size() == 0, "R9", "queues drained",
          64'(req_q.size() + rd_q.size()), 64'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule